// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normalizer

This block is a per-pin interrupt front end for a downstream interrupt controller that accepts only two trigger kinds: rising-edge pulses and active-high levels. Each of the `NPINS` wakeup inputs is first passed through a two-flop synchroniser. Its trigger type is then decoded from a 3-bit code held in that pin's 32-bit configuration word. Falling-edge, dual-edge and active-low inputs are turned into one-cycle high pulses or into active-high levels on `irq_out`. Bit 3 of the same word gates the pin.

Software programs the configuration words over a simple single-cycle register bus. Reads return data one cycle later. A read-only identification word is also on the bus. A write can replace the whole word. It can also carry a type-only qualifier, which replaces bits [2:0] and keeps the rest of the word. Some writes change a pin's type field while the pin stays enabled. After such a write the pin raises `stale_mark` for one cycle, so that the parent can drop any pending indication the change may have caused. During that cycle the pin's edge pulses are blocked.

Each pin runs a three-state machine:
- `PS_OFF`: the pin is disabled and its output is held low.
- `PS_LIVE`: the pin forwards levels and edge pulses.
- `PS_SETTLE`: a one-cycle state after a type change. Levels pass, edge pulses are masked and `stale_mark` is high.

The transitions are named as follows:
- *enable*: OFF to LIVE, on a write that sets the enable and keeps the type.
- *enable-retype*: OFF or LIVE to SETTLE, on a write that sets the enable and changes the type.
- *disable*: any state to OFF, on a write that clears the enable.
- *settle-done*: SETTLE to LIVE, in the cycle after, when no further type change arrives.
- *hold*: LIVE to LIVE, on any other cycle.

Top module: `wpn_norm`

## Requirements
- R1: After reset, every configuration word reads 0x00000004 (type level-high, disabled), and `irq_out` and `stale_mark` are all zero, even while inputs are high.
- R2: The configuration word of pin i is at byte address 0x110 + 4*i. A full write stores all 32 bits. A read of that address returns the stored word on `bus_rdata` in the cycle after the read strobe.
- R3: A read of address 0x1000 returns 0x00030200. Writes to that address are ignored. Reads of any other unmapped or misaligned address return zero. Writes to such addresses change no configuration word.
- R4: Bits [2:0] select the type. Code 000 (level active-low) drives the output to the inverse of the synchronised input. Code 100 (level active-high) drives it to the synchronised input.
- R5: Code 110 (rising) gives a single one-cycle pulse for each 0-to-1 input transition. Code 010 (falling) gives a single one-cycle pulse for each 1-to-0 transition. No other output activity occurs in these modes.
- R6: Code 111 (dual edge) gives a single one-cycle pulse for every input transition in either direction.
- R7: The unused codes 001, 011 and 101 keep the output low.
- R8: Bit 3 is the pin enable. While it is clear, the pin's `irq_out` stays low whatever the input does.
- R9: A write with `bus_type_only` high replaces only bits [2:0] of the addressed word. Bits [31:3], including the enable, keep their values.
- R10: An input change first appears on `irq_out` at the third rising clock edge after the change: two synchroniser stages plus the output register. Before that edge the output holds its previous value.
- R11: A write that changes a pin's type field and leaves it enabled raises that pin's `stale_mark` for exactly one cycle. Any edge pulse the pin would emit in the following cycle is suppressed. A write that leaves the type unchanged raises no mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPINS | Raw asynchronous wakeup inputs |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_type_only | input | 1 | With `bus_wr`, update only the type field [2:0] |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_out | output | NPINS | Normalised rising-edge / active-high interrupts |
| stale_mark | output | NPINS | One-cycle mark after a type change on an enabled pin |

## Verification
An input change is due on `irq_out` at the third rising edge after the change. The bench therefore drives each input on a falling edge and makes three checks: two falling edges later, where the old value must still hold; three falling edges later, for the pulse or new level; and four falling edges later, where the pulse must be gone. A register write takes effect at the edge it is presented to. Read data and `stale_mark` are checked at the falling edge right after the strobe's edge. In the masking test, a type-change write is timed to land on the edge where the synchronised transition is first visible, and the suppressed pulse is checked at the following falling edge. Every type code is swept with the enable both on and off on every pin. The expected levels and pulses are worked out arithmetically from the code, the enable and the old and new input values.

// File: rtl/wpn_pkg.sv
package wpn_pkg;
    localparam int CFG_W     = 32;
    localparam int CFG_BASE  = 32'h110;
    localparam int VER_ADDR  = 32'h1000;
    localparam logic [CFG_W-1:0] VER_VAL = 32'h0003_0200;
    localparam logic [CFG_W-1:0] CFG_RST = 32'h0000_0004;
    localparam int EN_BIT    = 3;

    localparam logic [2:0] TRG_LVL_LO = 3'b000;
    localparam logic [2:0] TRG_FALL   = 3'b010;
    localparam logic [2:0] TRG_LVL_HI = 3'b100;
    localparam logic [2:0] TRG_RISE   = 3'b110;
    localparam logic [2:0] TRG_DUAL   = 3'b111;

    typedef enum logic [1:0] {
        PS_OFF    = 2'd0,
        PS_LIVE   = 2'd1,
        PS_SETTLE = 2'd2
    } pin_state_e;
endpackage

// File: rtl/wpn_sync.sv
module wpn_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/wpn_regs.sv
module wpn_regs
    import wpn_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic                         bus_type_only,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [CFG_W-1:0]             bus_wdata,
    output logic [CFG_W-1:0]             bus_rdata,
    output logic [NPINS-1:0][CFG_W-1:0]  cfg_q,
    output logic [NPINS-1:0]             pin_wr,
    output logic [NPINS-1:0]             en_nx,
    output logic [NPINS-1:0]             type_chg
);
    localparam int IDX_W   = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam int CFG_END = CFG_BASE + 4 * NPINS;

    logic [ADDR_W-1:0] offs;
    logic              cfg_hit;
    logic [IDX_W-1:0]  idx;
    logic [NPINS-1:0][CFG_W-1:0] new_word;

    assign offs    = bus_addr - ADDR_W'(CFG_BASE);
    assign cfg_hit = (bus_addr >= ADDR_W'(CFG_BASE)) &&
                     (bus_addr <  ADDR_W'(CFG_END))  &&
                     (bus_addr[1:0] == 2'b00);
    assign idx     = offs[IDX_W+1:2];

    for (genvar i = 0; i < NPINS; i++) begin : g_word
        assign new_word[i] = bus_type_only ? {cfg_q[i][CFG_W-1:3], bus_wdata[2:0]}
                                           : bus_wdata;
        assign pin_wr[i]   = bus_wr && cfg_hit && (idx == IDX_W'(i));
        assign en_nx[i]    = new_word[i][EN_BIT];
        assign type_chg[i] = new_word[i][2:0] != cfg_q[i][2:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPINS; i++) cfg_q[i] <= CFG_RST;
        end else begin
            for (int i = 0; i < NPINS; i++)
                if (pin_wr[i]) cfg_q[i] <= new_word[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (bus_addr == ADDR_W'(VER_ADDR)) bus_rdata <= VER_VAL;
            else if (cfg_hit)                  bus_rdata <= cfg_q[idx];
            else                               bus_rdata <= '0;
        end
    end
endmodule

// File: rtl/wpn_pin.sv
module wpn_pin
    import wpn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sin,
    input  logic [2:0] trig,
    input  logic       cfg_wr,
    input  logic       cfg_en_nx,
    input  logic       cfg_tchg,
    output logic       irq,
    output logic       mark
);
    pin_state_e st, st_nx;
    logic       prev;
    logic       rise, fall, lvl_hit, edge_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PS_OFF;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            PS_OFF: begin
                if (cfg_wr && cfg_en_nx) st_nx = cfg_tchg ? PS_SETTLE : PS_LIVE;
            end
            PS_LIVE, PS_SETTLE: begin
                if (cfg_wr && !cfg_en_nx)     st_nx = PS_OFF;
                else if (cfg_wr && cfg_tchg)  st_nx = PS_SETTLE;
                else                          st_nx = PS_LIVE;
            end
            default: st_nx = PS_OFF;
        endcase
    end

    assign rise = sin && !prev;
    assign fall = !sin && prev;

    always_comb begin
        lvl_hit  = 1'b0;
        edge_hit = 1'b0;
        case (trig)
            TRG_LVL_LO: lvl_hit  = !sin;
            TRG_LVL_HI: lvl_hit  = sin;
            TRG_RISE:   edge_hit = rise;
            TRG_FALL:   edge_hit = fall;
            TRG_DUAL:   edge_hit = rise || fall;
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b0;
            irq  <= 1'b0;
        end else begin
            prev <= sin;
            irq  <= (st != PS_OFF) && (lvl_hit || (edge_hit && st == PS_LIVE));
        end
    end

    assign mark = (st == PS_SETTLE);
endmodule

// File: rtl/wpn_norm.sv
module wpn_norm
    import wpn_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_in,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_type_only,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NPINS-1:0]  irq_out,
    output logic [NPINS-1:0]  stale_mark
);
    logic [NPINS-1:0]            pin_s;
    logic [NPINS-1:0][CFG_W-1:0] cfg_q;
    logic [NPINS-1:0]            pin_wr, en_nx, type_chg;

    wpn_sync #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .d_sync  (pin_s)
    );

    wpn_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_type_only (bus_type_only),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .cfg_q         (cfg_q),
        .pin_wr        (pin_wr),
        .en_nx         (en_nx),
        .type_chg      (type_chg)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        wpn_pin u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .sin       (pin_s[i]),
            .trig      (cfg_q[i][2:0]),
            .cfg_wr    (pin_wr[i]),
            .cfg_en_nx (en_nx[i]),
            .cfg_tchg  (type_chg[i]),
            .irq       (irq_out[i]),
            .mark      (stale_mark[i])
        );
    end
endmodule

// File: rtl/wpn_chk.sv
module wpn_chk
    import wpn_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_wr,
    input logic                        bus_rd,
    input logic                        bus_type_only,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [31:0]                 bus_rdata,
    input logic [NPINS-1:0]            irq_out,
    input logic [NPINS-1:0]            stale_mark,
    input logic [NPINS-1:0][CFG_W-1:0] cfg_q
);
    localparam int CFG_END = CFG_BASE + 4 * NPINS;

    logic in_cfg;
    assign in_cfg = (bus_addr >= ADDR_W'(CFG_BASE)) && (bus_addr < ADDR_W'(CFG_END)) &&
                    (bus_addr[1:0] == 2'b00);

    // R3: identification word
    p_ver_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(VER_ADDR)) |=> (bus_rdata == VER_VAL));

    // R3: unmapped reads return zero
    p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != ADDR_W'(VER_ADDR) && !in_cfg) |=> (bus_rdata == 32'h0));

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        // R8: disabled pin stays quiet
        p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_q[i][EN_BIT] |=> !irq_out[i]);

        // R9: type-only write keeps bits [31:3]
        p_keep_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_type_only && bus_addr == ADDR_W'(CFG_BASE + 4 * i))
            |=> (cfg_q[i][CFG_W-1:3] == $past(cfg_q[i][CFG_W-1:3])));

        // R11: mark lasts one cycle without a new write
        p_mark_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (stale_mark[i] && !bus_wr) |=> !stale_mark[i]);

        // R11: edge pulses masked while marked
        p_mark_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (stale_mark[i] && cfg_q[i][1] && cfg_q[i][2:0] != 3'b011) |=> !irq_out[i]);
    end
endmodule

bind wpn_norm wpn_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_type_only (bus_type_only),
    .bus_addr      (bus_addr),
    .bus_rdata     (bus_rdata),
    .irq_out       (irq_out),
    .stale_mark    (stale_mark),
    .cfg_q         (cfg_q)
);

// File: tb/sim_wpn_norm.sv
module sim_wpn_norm;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_type_only = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] irq_out, stale_mark;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wpn_norm #(.NPINS(NP), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_type_only(bus_type_only),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .stale_mark(stale_mark)
    );

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic tonly);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_type_only = tonly;
        step();
        bus_wr = 1'b0; bus_type_only = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        step();
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    function automatic logic [AW-1:0] cfg_addr(input int p);
        return AW'(32'h110 + 4 * p);
    endfunction

    function automatic logic lvl(input int c, input int e, input logic x);
        return (e != 0) && ((c == 0 && !x) || (c == 4 && x));
    endfunction

    function automatic logic pul(input int c, input int e, input logic o, input logic n);
        return (e != 0) && ((c == 6 && !o && n) || (c == 2 && o && !n) || (c == 7 && o != n));
    endfunction

    function automatic bit is_edge(input int c);
        return c == 2 || c == 6 || c == 7;
    endfunction

    function automatic string tag(input int c, input int e);
        if (e == 0) return "R8";
        if (c == 0 || c == 4) return "R4";
        if (c == 2 || c == 6) return "R5";
        if (c == 7) return "R6";
        return "R7";
    endfunction

    task automatic transition(input int p, input int c, input int e, input logic o, input logic n);
        pin_in[p] = n;
        step(2);
        chk("R10 hold", 32'(irq_out[p]), 32'(lvl(c, e, o)));
        step();
        chk(tag(c, e), 32'(irq_out[p]), 32'(is_edge(c) ? pul(c, e, o, n) : lvl(c, e, n)));
        step();
        chk(tag(c, e), 32'(irq_out[p]), 32'(lvl(c, e, n)));
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] w;
        pin_in = '1;
        step(3);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 irq", 32'(irq_out), 32'h0);
        chk("R1 mark", 32'(stale_mark), 32'h0);
        for (int p = 0; p < NP; p++) begin
            rd(cfg_addr(p), d);
            chk("R1 cfg", d, 32'h4);
        end
        step(3);
        chk("R1 irq high inputs", 32'(irq_out), 32'h0);
        pin_in = '0;
        step(4);

        // R2/R4-R8/R10: sweep of every code and enable on every pin
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < 8; c++) begin
                for (int e = 0; e < 2; e++) begin
                    w = 32'hC3A5_0000 | (32'(e) << 3) | 32'(c);
                    pin_in[p] = 1'b0;
                    wr(cfg_addr(p), w, 1'b0);
                    step(4);
                    chk(tag(c, e), 32'(irq_out[p]), 32'(lvl(c, e, 1'b0)));
                    rd(cfg_addr(p), d);
                    chk("R2", d, w);
                    transition(p, c, e, 1'b0, 1'b1);
                    step(2);
                    transition(p, c, e, 1'b1, 1'b0);
                end
            end
        end

        // R11: type change masks the in-flight edge pulse
        wr(cfg_addr(0), 32'h0000_000F, 1'b0);
        pin_in[0] = 1'b0;
        step(5);
        pin_in[0] = 1'b1;
        step();
        wr(cfg_addr(0), 32'h0000_0006, 1'b1);
        chk("R11 mark", 32'(stale_mark[0]), 32'h1);
        step();
        chk("R11 masked", 32'(irq_out[0]), 32'h0);
        chk("R11 mark once", 32'(stale_mark[0]), 32'h0);
        rd(cfg_addr(0), d);
        chk("R9 type only", d, 32'h0000_000E);
        // R11 control: unchanged type, pulse passes
        pin_in[0] = 1'b0;
        step(5);
        pin_in[0] = 1'b1;
        step();
        wr(cfg_addr(0), 32'h0000_0006, 1'b1);
        chk("R11 no mark", 32'(stale_mark[0]), 32'h0);
        step();
        chk("R11 R5 pulse", 32'(irq_out[0]), 32'h1);

        // R9: type-only writes keep upper bits
        wr(cfg_addr(2), 32'hDEAD_BEE8, 1'b0);
        wr(cfg_addr(2), 32'h0000_0007, 1'b1);
        rd(cfg_addr(2), d);
        chk("R9", d, 32'hDEAD_BEEF);
        wr(cfg_addr(2), 32'hFFFF_FFF2, 1'b1);
        rd(cfg_addr(2), d);
        chk("R9", d, 32'hDEAD_BEEA);

        // R3: version, ignored and unmapped accesses
        rd(AW'(32'h1000), d);
        chk("R3 version", d, 32'h0003_0200);
        wr(AW'(32'h1000), 32'h0, 1'b0);
        rd(AW'(32'h1000), d);
        chk("R3 version write ignored", d, 32'h0003_0200);
        rd(AW'(32'h0200), d);
        chk("R3 unmapped read", d, 32'h0);
        wr(AW'(32'h0112), 32'h1234_5678, 1'b0);
        wr(AW'(32'h0110 + 4 * NP), 32'h1234_5678, 1'b0);
        rd(cfg_addr(0), d);
        chk("R3 misaligned write ignored", d, 32'h0000_000E);
        rd(cfg_addr(NP - 1), d);
        chk("R3 out-of-range write ignored", d[31:16], 32'hC3A5);
        rd(AW'(32'h0112), d);
        chk("R3 misaligned read", d, 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule